// File: doc/BRIEF.md
# Self-Checking Integer ALU with Operand Duplication and Two-Pass Fallback

This block is a 32-bit integer ALU that checks every result it returns for transient upsets. A request carries an operation code and two operands. When both operands fit a half-width signed datapath, the block places a copy of the low halves in the upper half of the operand buses. It runs the ALU once in split-lane mode. Both lanes then compute the same 16-bit function in the same cycle, and the block compares the two lanes.

Operations that do not fit are run twice through the full-width ALU on two consecutive cycles, and the two results are compared. This also covers an add or subtract whose 16-bit result would overflow, a left shift that would push significant bits out of the lane, and a logical right shift of a negative value. Any disagreement between the two copies raises an error flag in the cycle the result is delivered. The block only reports the mismatch. Retry and recovery are left to the surrounding pipeline.

A fault-injection input is XORed onto the raw ALU output on every cycle. It stands for an upset on the datapath and lets the detection path be exercised.

Top module: `dup_check_alu`

## Requirements
- R1: Operation codes are ADD=0, SUB=1 (a minus b), AND=2, OR=3, XOR=4, SLL=5, SRL=6, SRA=7. The shift amount is `in_b[4:0]`. With no injected fault, `out_res` equals the 32-bit two's-complement result of the operation.
- R2: An operand is small when its bits 31..15 are all equal. ADD, SUB, AND, OR and XOR with both operands small, and no 16-bit signed overflow for ADD or SUB, complete on the single-pass path. On that path `out_done` is high in the cycle right after acceptance.
- R3: ADD or SUB with both operands small whose 16-bit signed result overflows takes the two-pass path.
- R4: The shift amount qualifies when `in_b[4]` is 0. SRA qualifies when `in_a` is small. SLL qualifies when `in_a` is small and the shifted value is still small. SRL qualifies only when `in_a` lies in 0..32767. Any other shift takes the two-pass path.
- R5: On the two-pass path, `in_rdy` is low for exactly one cycle after acceptance. `out_done` rises in the second cycle after acceptance.
- R6: A request is accepted only while `in_rdy` is high. A strobe on `in_vld` while `in_rdy` is low is ignored and produces no completion.
- R7: On the single-pass path, `out_err` is high with `out_done` when the two lanes of the ALU output differ. `out_res` is then the lower lane sign-extended, after injection.
- R8: On the two-pass path, `out_err` is high with `out_done` when the two passes differ. `out_res` is the second pass.
- R9: `out_err` is high only in cycles in which `out_done` is high.
- R10: `out_res` holds its value in every cycle in which `out_done` is low.
- R11: After reset, `in_rdy`=1, `out_done`=0, `out_err`=0 and `out_res`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_vld | input | 1 | Request strobe |
| in_op | input | 3 | Operation code |
| in_a | input | 32 | First operand |
| in_b | input | 32 | Second operand or shift amount |
| flt_inj | input | 32 | Fault pattern XORed onto the raw ALU output each cycle |
| in_rdy | output | 1 | Block idle, request may be accepted |
| out_done | output | 1 | Result valid this cycle |
| out_res | output | 32 | Result |
| out_err | output | 1 | Copies disagreed for this result |

## Verification
The checker assumes that `in_vld`, `in_op` and the operands are clean, known values at every rising edge after reset. It also assumes that a strobe raised while `in_rdy` is low will be dropped rather than held. The bench changes inputs only on falling edges and drives `in_vld` for a single cycle per request. It raises the strobe during a busy cycle only in a directed case that checks that it is ignored. Random operands are drawn half from the small range and half from the full range, so both paths are exercised heavily. Fault patterns are mostly single bits applied in one chosen cycle, so the expected error flag follows directly from the path taken.

// File: rtl/dca_pkg.sv
`timescale 1ns/1ps
package dca_pkg;
   typedef enum logic [2:0] {
      OP_ADD = 3'd0,
      OP_SUB = 3'd1,
      OP_AND = 3'd2,
      OP_OR  = 3'd3,
      OP_XOR = 3'd4,
      OP_SLL = 3'd5,
      OP_SRL = 3'd6,
      OP_SRA = 3'd7
   } alu_op_e;

   typedef enum logic {
      ST_IDLE  = 1'b0,
      ST_AGAIN = 1'b1
   } chk_state_e;
endpackage

// File: rtl/dca_qualify.sv
`timescale 1ns/1ps
// Decides whether a request can run as two half-width copies in one pass.
module dca_qualify #(
   parameter int W = 32
) (
   input  logic [2:0]   op,
   input  logic [W-1:0] a,
   input  logic [W-1:0] b,
   output logic         dup_ok
);
   import dca_pkg::*;

   localparam int H   = W / 2;
   localparam int SHW = $clog2(W);
   localparam logic [SHW-2:0] LMAX = (SHW-1)'(H - 1);

   alu_op_e        opc;
   logic           sm_a, sm_b, pos_a, amt_ok;
   logic [SHW-2:0] lamt, back;
   logic [H-1:0]   bb, probe;
   logic           cin, c_msb, c_out, ovf, sll_ok;

   assign opc    = alu_op_e'(op);
   assign sm_a   = (a[W-1:H-1] == {(H+1){a[H-1]}});
   assign sm_b   = (b[W-1:H-1] == {(H+1){b[H-1]}});
   assign pos_a  = ~(|a[W-1:H-1]);
   assign amt_ok = ~b[SHW-1];
   assign lamt   = b[SHW-2:0];

   // half-width signed overflow of add/sub: carry into msb vs carry out
   assign cin   = (opc == OP_SUB);
   assign bb    = cin ? ~b[H-1:0] : b[H-1:0];
   assign c_msb = 1'(({1'b0, a[H-2:0]} + {1'b0, bb[H-2:0]} + H'(cin)) >> (H-1));
   assign c_out = (a[H-1] & bb[H-1]) | (c_msb & (a[H-1] ^ bb[H-1]));
   assign ovf   = c_msb ^ c_out;

   // left shift keeps the lane when the top (amt+1) bits agree
   assign back   = LMAX - lamt;
   assign probe  = $signed(a[H-1:0]) >>> back;
   assign sll_ok = (&probe) | ~(|probe);

   always_comb begin
      case (opc)
         OP_ADD, OP_SUB:        dup_ok = sm_a & sm_b & ~ovf;
         OP_AND, OP_OR, OP_XOR: dup_ok = sm_a & sm_b;
         OP_SLL:                dup_ok = sm_a & amt_ok & sll_ok;
         OP_SRL:                dup_ok = pos_a & amt_ok;
         default:               dup_ok = sm_a & amt_ok;
      endcase
   end
endmodule

// File: rtl/dca_core.sv
`timescale 1ns/1ps
// Integer ALU whose carry chain and shifters can be cut into NL lanes.
module dca_core #(
   parameter int W  = 32,
   parameter int NL = 2
) (
   input  logic [2:0]   op,
   input  logic         split,
   input  logic [W-1:0] x,
   input  logic [W-1:0] y,
   output logic [W-1:0] r
);
   import dca_pkg::*;

   localparam int LW  = W / NL;
   localparam int SHW = $clog2(W);
   localparam int LSH = $clog2(LW);

   if (NL < 2 || (W % NL) != 0 || LW < 4) begin : g_bad_lanes
      $error("dca_core: W must split into at least two lanes of 4+ bits");
   end

   alu_op_e        opc;
   logic           sub;
   logic [W-1:0]   yb, sum, lsh;
   logic [NL-1:0]  cy;
   logic [SHW-1:0] amt;

   assign opc   = alu_op_e'(op);
   assign sub   = (opc == OP_SUB);
   assign yb    = sub ? ~y : y;
   assign cy[0] = sub;
   assign amt   = y[SHW-1:0];

   for (genvar g = 0; g < NL; g++) begin : g_lane
      logic           cin;
      logic [LW:0]    ls;
      logic [LW-1:0]  lx;
      logic [LSH-1:0] lamt;

      assign cin  = split ? sub : cy[g];
      assign ls   = {1'b0, x[g*LW +: LW]} + {1'b0, yb[g*LW +: LW]} + {{LW{1'b0}}, cin};
      assign sum[g*LW +: LW] = ls[LW-1:0];
      assign lx   = x[g*LW +: LW];
      assign lamt = y[g*LW +: LSH];

      if (g < NL-1) begin : g_carry
         assign cy[g+1] = ls[LW];
      end

      always_comb begin
         case (opc)
            OP_SLL:  lsh[g*LW +: LW] = lx << lamt;
            OP_SRL:  lsh[g*LW +: LW] = lx >> lamt;
            default: lsh[g*LW +: LW] = $signed(lx) >>> lamt;
         endcase
      end
   end

   always_comb begin
      case (opc)
         OP_ADD, OP_SUB: r = sum;
         OP_AND:         r = x & y;
         OP_OR:          r = x | y;
         OP_XOR:         r = x ^ y;
         OP_SLL:         r = split ? lsh : (x << amt);
         OP_SRL:         r = split ? lsh : (x >> amt);
         default:        r = split ? lsh : W'($signed(x) >>> amt);
      endcase
   end
endmodule

// File: rtl/dup_check_alu.sv
`timescale 1ns/1ps
// Checked ALU: same-cycle lane duplication for small operands,
// two consecutive full-width passes otherwise.
module dup_check_alu #(
   parameter int W = 32
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         in_vld,
   input  logic [2:0]   in_op,
   input  logic [W-1:0] in_a,
   input  logic [W-1:0] in_b,
   input  logic [W-1:0] flt_inj,
   output logic         in_rdy,
   output logic         out_done,
   output logic [W-1:0] out_res,
   output logic         out_err
);
   import dca_pkg::*;

   localparam int NL = 2;
   localparam int H  = W / NL;

   if (W < 8 || (W & (W - 1)) != 0) begin : g_bad_width
      $error("dup_check_alu: W must be a power of two, at least 8");
   end

   chk_state_e   st_q;
   logic [2:0]   op_q;
   logic [W-1:0] a_q, b_q, first_q;
   logic         dup_ok, c_split;
   logic [2:0]   c_op;
   logic [W-1:0] c_x, c_y, c_raw, c_out;
   logic [H-1:0] lane_lo, lane_hi;
   logic         take;

   dca_qualify #(.W(W)) u_qual (
      .op     (in_op),
      .a      (in_a),
      .b      (in_b),
      .dup_ok (dup_ok)
   );

   always_comb begin
      if (st_q == ST_AGAIN) begin
         c_op    = op_q;
         c_x     = a_q;
         c_y     = b_q;
         c_split = 1'b0;
      end else begin
         c_op    = in_op;
         c_split = dup_ok;
         c_x     = dup_ok ? {NL{in_a[H-1:0]}} : in_a;
         c_y     = dup_ok ? {NL{in_b[H-1:0]}} : in_b;
      end
   end

   dca_core #(.W(W), .NL(NL)) u_core (
      .op    (c_op),
      .split (c_split),
      .x     (c_x),
      .y     (c_y),
      .r     (c_raw)
   );

   assign c_out   = c_raw ^ flt_inj;
   assign lane_lo = c_out[H-1:0];
   assign lane_hi = c_out[W-1:H];
   assign take    = in_vld && (st_q == ST_IDLE);
   assign in_rdy  = (st_q == ST_IDLE);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q     <= ST_IDLE;
         op_q     <= '0;
         a_q      <= '0;
         b_q      <= '0;
         first_q  <= '0;
         out_done <= 1'b0;
         out_err  <= 1'b0;
         out_res  <= '0;
      end else begin
         out_done <= 1'b0;
         out_err  <= 1'b0;
         if (st_q == ST_AGAIN) begin
            out_res  <= c_out;
            out_err  <= (c_out != first_q);
            out_done <= 1'b1;
            st_q     <= ST_IDLE;
         end else if (take) begin
            if (dup_ok) begin
               out_res  <= {{H{lane_lo[H-1]}}, lane_lo};
               out_err  <= (lane_lo != lane_hi);
               out_done <= 1'b1;
            end else begin
               first_q <= c_out;
               op_q    <= in_op;
               a_q     <= in_a;
               b_q     <= in_b;
               st_q    <= ST_AGAIN;
            end
         end
      end
   end
endmodule

// File: rtl/dup_check_alu_chk.sv
`timescale 1ns/1ps
module dup_check_alu_chk #(
   parameter int W = 32
) (
   input logic         clk,
   input logic         rst_n,
   input logic         in_vld,
   input logic [2:0]   in_op,
   input logic [W-1:0] in_a,
   input logic [W-1:0] in_b,
   input logic         in_rdy,
   input logic         out_done,
   input logic [W-1:0] out_res,
   input logic         out_err
);
   localparam int H = W / 2;

   logic small_ab, logic_op;
   assign small_ab = ($signed(in_a) >= -$signed(W'(1) << (H-1))) &&
                     ($signed(in_a) <   $signed(W'(1) << (H-1))) &&
                     ($signed(in_b) >= -$signed(W'(1) << (H-1))) &&
                     ($signed(in_b) <   $signed(W'(1) << (H-1)));
   assign logic_op = (in_op == 3'd2) || (in_op == 3'd3) || (in_op == 3'd4);

   p_err_with_done_r9: assert property (@(posedge clk) disable iff (!rst_n)
      out_err |-> out_done);

   p_busy_one_cycle_r5: assert property (@(posedge clk) disable iff (!rst_n)
      !in_rdy |=> (in_rdy && out_done));

   p_accept_resolves_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (in_vld && in_rdy) |=> (out_done || !in_rdy));

   p_done_has_cause_r6: assert property (@(posedge clk) disable iff (!rst_n)
      out_done |-> ($past(in_vld && in_rdy) || $past(!in_rdy)));

   p_small_logic_single_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (in_vld && in_rdy && logic_op && small_ab) |=> (out_done && in_rdy));

   p_res_held_r10: assert property (@(posedge clk) disable iff (!rst_n)
      !out_done |-> $stable(out_res));
endmodule

bind dup_check_alu dup_check_alu_chk #(.W(W)) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .in_vld   (in_vld),
   .in_op    (in_op),
   .in_a     (in_a),
   .in_b     (in_b),
   .in_rdy   (in_rdy),
   .out_done (out_done),
   .out_res  (out_res),
   .out_err  (out_err)
);

// File: tb/dup_check_alu_tb_top.sv
`timescale 1ns/1ps
module dup_check_alu_tb_top;
   localparam int W = 32;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         in_vld = 1'b0;
   logic [2:0]   in_op = '0;
   logic [W-1:0] in_a = '0, in_b = '0, flt_inj = '0;
   logic         in_rdy, out_done, out_err;
   logic [W-1:0] out_res;

   int nchk = 0;
   int nfail = 0;

   always #2.5 clk = ~clk;

   dup_check_alu #(.W(W)) dut_i (
      .clk(clk), .rst_n(rst_n), .in_vld(in_vld), .in_op(in_op),
      .in_a(in_a), .in_b(in_b), .flt_inj(flt_inj), .in_rdy(in_rdy),
      .out_done(out_done), .out_res(out_res), .out_err(out_err)
   );

   task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
      nchk++;
      if (!ok) begin
         nfail++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   function automatic logic [31:0] ref_res(input logic [2:0] op, input logic [31:0] a, input logic [31:0] b);
      case (op)
         3'd0: return a + b;
         3'd1: return a - b;
         3'd2: return a & b;
         3'd3: return a | b;
         3'd4: return a ^ b;
         3'd5: return a << b[4:0];
         3'd6: return a >> b[4:0];
         default: return 32'($signed(a) >>> b[4:0]);
      endcase
   endfunction

   function automatic bit fits16(input longint v);
      return (v >= -32768) && (v <= 32767);
   endfunction

   function automatic bit pred_single(input logic [2:0] op, input logic [31:0] a, input logic [31:0] b);
      longint sa, sb;
      sa = longint'($signed(a));
      sb = longint'($signed(b));
      case (op)
         3'd0: return fits16(sa) && fits16(sb) && fits16(sa + sb);
         3'd1: return fits16(sa) && fits16(sb) && fits16(sa - sb);
         3'd2, 3'd3, 3'd4: return fits16(sa) && fits16(sb);
         3'd5: return fits16(sa) && (b[4:0] < 16) && fits16(sa * (longint'(1) << b[4:0]));
         3'd6: return (a <= 32'd32767) && (b[4:0] < 16);
         default: return fits16(sa) && (b[4:0] < 16);
      endcase
   endfunction

   // one request; inj0 in the accept cycle, inj1 in the following cycle
   task automatic run_op(input logic [2:0] op, input logic [31:0] a, input logic [31:0] b,
                         input logic [31:0] inj0, input logic [31:0] inj1, input bit poke);
      bit single;
      logic [31:0] r, exp_res;
      bit exp_err;
      single = pred_single(op, a, b);
      r = ref_res(op, a, b);
      @(negedge clk);
      chk(in_rdy == 1'b1, "R6 ready before request", {31'b0, in_rdy}, 32'd1);
      in_vld = 1'b1; in_op = op; in_a = a; in_b = b; flt_inj = inj0;
      @(negedge clk);
      in_vld = 1'b0; flt_inj = inj1;
      if (single) begin
         exp_res = {{16{r[15] ^ inj0[15]}}, r[15:0] ^ inj0[15:0]};
         exp_err = (inj0[15:0] != inj0[31:16]);
         chk(out_done == 1'b1 && in_rdy == 1'b1, (op >= 3'd5) ? "R4 single-pass shift" : "R2 single-pass latency",
             {30'b0, in_rdy, out_done}, 32'd3);
         chk(out_res == exp_res, "R1 R7 single-pass result", out_res, exp_res);
         chk(out_err == exp_err, "R7 lane compare", {31'b0, out_err}, {31'b0, exp_err});
      end else begin
         exp_res = r ^ inj1;
         exp_err = (inj0 != inj1);
         chk(out_done == 1'b0 && in_rdy == 1'b0, "R3 R5 two-pass busy cycle", {30'b0, in_rdy, out_done}, 32'd0);
         if (poke) begin
            in_vld = 1'b1; in_op = 3'd2; in_a = 32'd5; in_b = 32'd3;
         end
         @(negedge clk);
         in_vld = 1'b0; flt_inj = '0;
         chk(out_done == 1'b1 && in_rdy == 1'b1, "R5 two-pass done", {30'b0, in_rdy, out_done}, 32'd3);
         chk(out_res == exp_res, "R1 R8 two-pass result", out_res, exp_res);
         chk(out_err == exp_err, "R8 pass compare", {31'b0, out_err}, {31'b0, exp_err});
         chk(!(out_err && !out_done), "R9 error only with done", {31'b0, out_err}, {31'b0, out_done});
         if (poke) begin
            @(negedge clk);
            chk(out_done == 1'b0, "R6 busy strobe ignored", {31'b0, out_done}, 32'd0);
            chk(out_res == exp_res, "R10 result held", out_res, exp_res);
         end
      end
   endtask

   function automatic logic [31:0] rnd_operand();
      logic [31:0] v;
      v = $urandom;
      if ($urandom % 2 == 0) v = {{16{v[15]}}, v[15:0]};
      return v;
   endfunction

   initial begin
      #1000000;
      nfail++;
      $display("FAIL watchdog all-requirements actual=hung expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
      $finish;
   end

   initial begin
      void'($urandom(32'd20250));
      repeat (3) @(negedge clk);
      chk(in_rdy == 1'b1 && out_done == 1'b0 && out_err == 1'b0 && out_res == '0,
          "R11 reset state", {29'b0, in_rdy, out_done, out_err}, 32'd4);
      rst_n = 1'b1;
      @(negedge clk);
      chk(in_rdy == 1'b1 && out_done == 1'b0 && out_res == '0, "R11 after release",
          out_res, 32'd0);

      // R2 / R3 arithmetic corners
      run_op(3'd0, 32'd100, 32'd200, '0, '0, 0);
      run_op(3'd0, 32'd32767, 32'd1, '0, '0, 0);              // R3 overflow
      run_op(3'd1, 32'hFFFF8000, 32'd1, '0, '0, 0);           // R3 overflow
      run_op(3'd1, 32'hFFFFFF00, 32'd55, '0, '0, 0);
      run_op(3'd0, 32'h12345678, 32'h0F0F0F0F, '0, '0, 0);
      run_op(3'd2, 32'hFFFFF0F0, 32'h00000FFF, '0, '0, 0);
      run_op(3'd4, 32'h00010000, 32'd7, '0, '0, 0);
      run_op(3'd3, 32'hFFFF8000, 32'h00007FFF, '0, '0, 0);
      // R4 shift corners
      run_op(3'd5, 32'd3, 32'd4, '0, '0, 0);
      run_op(3'd5, 32'd1, 32'd15, '0, '0, 0);                 // 0x8000 leaves lane
      run_op(3'd5, 32'hFFFFFFFF, 32'd15, '0, '0, 0);
      run_op(3'd5, 32'd1, 32'd16, '0, '0, 0);
      run_op(3'd6, 32'hFFFFFFFC, 32'd1, '0, '0, 0);
      run_op(3'd6, 32'd100, 32'hFFFFFFE3, '0, '0, 0);
      run_op(3'd7, 32'hFFFFFF9C, 32'd3, '0, '0, 0);
      run_op(3'd7, 32'h80000000, 32'd20, '0, '0, 0);
      // R7 / R8 injected upsets
      run_op(3'd0, 32'd10, 32'd20, 32'h00000004, '0, 0);
      run_op(3'd2, 32'd10, 32'd20, 32'h00400000, '0, 0);
      run_op(3'd0, 32'h40000000, 32'd1, 32'h00000100, '0, 0);
      run_op(3'd0, 32'h40000000, 32'd1, '0, 32'h80000000, 0);
      run_op(3'd3, 32'h40000000, 32'd1, 32'h00000001, 32'h00000001, 0);
      // R6 / R10 strobe during busy cycle
      run_op(3'd4, 32'hDEADBEEF, 32'h01234567, '0, '0, 1);

      for (int i = 0; i < 3000; i++) begin
         logic [31:0] i0, i1;
         int sel;
         i0 = '0; i1 = '0;
         sel = $urandom % 10;
         if (sel == 0) i0 = 32'd1 << ($urandom % 32);
         if (sel == 1) i1 = 32'd1 << ($urandom % 32);
         run_op(3'($urandom % 8), rnd_operand(), rnd_operand(), i0, i1, ($urandom % 16) == 0);
      end

      $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
      $finish;
   end
endmodule